// File: doc/BRIEF.md
# Transmit Descriptor Sequencer

This block walks a ring of transmit buffer descriptors held in an external descriptor memory and turns the buffers into a byte stream for a MAC. Each descriptor holds a 16-bit status word, a 16-bit byte count and a buffer address. Software fills in a descriptor with its ready flag set and then writes the kick bit. The engine then fetches descriptors one after another. For each ready descriptor it reads the buffer out of a byte-wide buffer memory and presents the bytes on a valid/ready stream. It then writes the status back with the ready flag cleared and moves to the next ring slot.

Descriptors without the end-of-frame flag chain into the next slot as part of the same frame. The engine stops when it fetches a descriptor whose ready flag is clear. It clears the ready flag before the next fetch, so a lone descriptor that wraps onto itself is sent only once. A graceful-stop control bit lets the frame in flight finish and then raises a stop-complete event. While that bit stays set, the engine starts no new frame.

Top module: `tdf_tx_engine`

## Requirements
- R1: After reset, evt_o, active_o, fdx_o and tx_valid_o are all 0 and desc_addr_o is 0.
- R2: A write to register 1 with bit 24 set starts the engine. For each fetched descriptor with status bit 15 (ready) set, the bytes at buffer addresses pointer..pointer+length-1 appear on tx_data_o in address order. Descriptor layout on desc_rdata_i: [15:0] status, [31:16] length, [63:32] pointer.
- R3: tx_last_o is 1 only on the final byte of a descriptor with status bit 11 (end of frame) set. On that byte tx_crc_o equals status bit 10 (append CRC). On every other byte both are 0.
- R4: After the last byte, the engine writes the descriptor's status back with bit 15 cleared and every other bit unchanged. The same write sets event bit 1 (descriptor done).
- R5: After a write-back, desc_addr_o moves to the next slot. It wraps to 0 when status bit 13 (wrap) was set or the slot was the last in the ring.
- R6: Fetching a descriptor whose bit 15 is clear sends no bytes, writes nothing and drops active_o to 0.
- R7: A single descriptor with both wrap and ready set is sent exactly once per kick.
- R8: A ready descriptor without bit 11 continues the frame into the next slot, and no tx_last_o is given between them.
- R9: Register 0 bit 0 (graceful stop) lets the current frame finish, then sets event bit 0. While that bit stays set, no further ready descriptor is sent. Clearing it resumes the ring without a new kick.
- R10: A write to register 2 clears each event bit whose data bit is 1. An event raised in the same cycle as its clear stays set.
- R11: fdx_o follows bit 2 of register 0.
- R12: While tx_valid_o is 1 and tx_ready_i is 0, tx_valid_o stays 1 and tx_data_o stays unchanged.
- R13: A ready descriptor with length 0 sends no bytes but is still written back and advanced past.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select: 0 control, 1 kick, 2 events |
| reg_wdata_i | input | 32 | Register write data |
| evt_o | output | 2 | Event flags: bit 0 stop complete, bit 1 descriptor done |
| active_o | output | 1 | Ring active (kicked and not yet halted on an empty slot) |
| fdx_o | output | 1 | Full-duplex setting to the MAC |
| desc_rd_o | output | 1 | Descriptor read request; data is expected on the next cycle |
| desc_wr_o | output | 1 | Descriptor status write-back strobe |
| desc_addr_o | output | 2 | Current ring slot |
| desc_rdata_i | input | 64 | Descriptor read data |
| desc_wdata_o | output | 16 | Status word written back |
| buf_rd_o | output | 1 | Buffer byte read request; data is expected on the next cycle |
| buf_addr_o | output | 32 | Buffer byte address |
| buf_rdata_i | input | 8 | Buffer byte read data |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a frame |
| tx_crc_o | output | 1 | CRC append request, given with tx_last_o |

## Verification
Two functions can fall in the same cycle: the engine raising the descriptor-done event during a status write-back, and software clearing that same event bit. The bench sets up the collision first by leaving the done bit pending. It then watches for the write-back strobe on the descriptor port and drives the clearing register write in that same clock. After the edge, the done bit must still read 1. Ordinary clearing is checked separately, so a design in which the clear wins, or in which the clear does nothing, is reported.

// File: rtl/tdf_pkg.sv
package tdf_pkg;
  localparam int STAT_W   = 16;
  localparam int RDY_BIT  = 15;
  localparam int WRAP_BIT = 13;
  localparam int LAST_BIT = 11;
  localparam int CRC_BIT  = 10;

  localparam int KICK_BIT = 24;
  localparam int GTS_BIT  = 0;
  localparam int FDX_BIT  = 2;

  localparam int EVT_STOP = 0;
  localparam int EVT_DONE = 1;
  localparam int EVT_W    = 2;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_KICK = 2'd1;
  localparam logic [1:0] REG_EVT  = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CHECK, S_BRD, S_BCAP, S_SEND, S_WB
  } seq_state_e;
endpackage

// File: rtl/tdf_regs.sv
module tdf_regs
  import tdf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              set_done_i,
  input  logic              set_stop_i,
  input  logic              clr_active_i,
  output logic              gts_o,
  output logic              fdx_o,
  output logic              active_o,
  output logic [EVT_W-1:0]  evt_o
);
  logic             wr_ctrl, wr_kick, wr_evt;
  logic [EVT_W-1:0] evt_set, evt_clr;
  logic             unused_wdata;

  assign wr_ctrl = wr_i && (addr_i == REG_CTRL);
  assign wr_kick = wr_i && (addr_i == REG_KICK) && wdata_i[KICK_BIT];
  assign wr_evt  = wr_i && (addr_i == REG_EVT);

  assign evt_clr = wr_evt ? wdata_i[EVT_W-1:0] : '0;
  always_comb begin
    evt_set           = '0;
    evt_set[EVT_DONE] = set_done_i;
    evt_set[EVT_STOP] = set_stop_i;
  end

  assign unused_wdata = ^{wdata_i[31:KICK_BIT+1], wdata_i[KICK_BIT-1:FDX_BIT+1],
                          wdata_i[FDX_BIT-1:GTS_BIT+1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gts_o    <= 1'b0;
      fdx_o    <= 1'b0;
      active_o <= 1'b0;
      evt_o    <= '0;
    end else begin
      if (wr_ctrl) begin
        gts_o <= wdata_i[GTS_BIT];
        fdx_o <= wdata_i[FDX_BIT];
      end
      // a kick in the same cycle as an empty-slot halt keeps the ring active
      if (wr_kick)           active_o <= 1'b1;
      else if (clr_active_i) active_o <= 1'b0;
      // set wins over a simultaneous clear
      evt_o <= (evt_o & ~evt_clr) | evt_set;
    end
  end
endmodule

// File: rtl/tdf_ring_ptr.sv
module tdf_ring_ptr #(
  parameter int RING_N = 4,
  localparam int IDX_W = (RING_N > 1) ? $clog2(RING_N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             wrap_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        idx_o <= '0;
    else if (adv_i) begin
      if (wrap_i || idx_o == LAST_IDX)  idx_o <= '0;
      else                              idx_o <= idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/tdf_seq.sv
module tdf_seq
  import tdf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int DESC_W = STAT_W + LEN_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              gts_i,
  output logic              desc_rd_o,
  output logic              desc_wr_o,
  input  logic [DESC_W-1:0] desc_rdata_i,
  output logic [STAT_W-1:0] desc_wdata_o,
  output logic              buf_rd_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_crc_o,
  output logic              adv_o,
  output logic              wrap_o,
  output logic              clr_active_o,
  output logic              set_done_o,
  output logic              set_stop_o
);
  seq_state_e        state_q, state_d;
  logic [STAT_W-1:0] stat_q;
  logic [LEN_W-1:0]  len_q, cnt_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [7:0]        byte_q;
  logic              stopped_q;

  logic [STAT_W-1:0] f_stat;
  logic [LEN_W-1:0]  f_len;
  logic [ADDR_W-1:0] f_ptr;
  logic              final_byte;

  assign f_stat = desc_rdata_i[STAT_W-1:0];
  assign f_len  = desc_rdata_i[STAT_W+LEN_W-1:STAT_W];
  assign f_ptr  = desc_rdata_i[DESC_W-1:STAT_W+LEN_W];

  assign final_byte = (cnt_q == len_q - 1'b1);

  always_comb begin
    state_d      = state_q;
    desc_rd_o    = 1'b0;
    desc_wr_o    = 1'b0;
    buf_rd_o     = 1'b0;
    tx_valid_o   = 1'b0;
    tx_last_o    = 1'b0;
    tx_crc_o     = 1'b0;
    adv_o        = 1'b0;
    clr_active_o = 1'b0;
    set_done_o   = 1'b0;
    set_stop_o   = 1'b0;
    case (state_q)
      S_IDLE: begin
        // frame boundary: the only place a graceful stop takes effect
        if (gts_i) set_stop_o = !stopped_q;
        else if (active_i) state_d = S_FETCH;
      end
      S_FETCH: begin
        desc_rd_o = 1'b1;
        state_d   = S_CHECK;
      end
      S_CHECK: begin
        if (!f_stat[RDY_BIT]) begin
          clr_active_o = 1'b1;
          state_d      = S_IDLE;
        end else if (f_len == '0) state_d = S_WB;
        else                      state_d = S_BRD;
      end
      S_BRD: begin
        buf_rd_o = 1'b1;
        state_d  = S_BCAP;
      end
      S_BCAP: state_d = S_SEND;
      S_SEND: begin
        tx_valid_o = 1'b1;
        tx_last_o  = final_byte && stat_q[LAST_BIT];
        tx_crc_o   = final_byte && stat_q[LAST_BIT] && stat_q[CRC_BIT];
        if (tx_ready_i) state_d = final_byte ? S_WB : S_BRD;
      end
      S_WB: begin
        // ready is cleared here, before any later fetch can see it
        desc_wr_o  = 1'b1;
        set_done_o = 1'b1;
        adv_o      = 1'b1;
        state_d    = stat_q[LAST_BIT] ? S_IDLE : S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign desc_wdata_o = stat_q & ~(STAT_W'(1) << RDY_BIT);
  assign wrap_o       = stat_q[WRAP_BIT];
  assign buf_addr_o   = ptr_q + ADDR_W'(cnt_q);
  assign tx_data_o    = byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      stat_q    <= '0;
      len_q     <= '0;
      ptr_q     <= '0;
      cnt_q     <= '0;
      byte_q    <= '0;
      stopped_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE) stopped_q <= gts_i;
      if (state_q == S_CHECK) begin
        stat_q <= f_stat;
        len_q  <= f_len;
        ptr_q  <= f_ptr;
        cnt_q  <= '0;
      end
      if (state_q == S_BCAP) byte_q <= buf_rdata_i;
      if (state_q == S_SEND && tx_ready_i) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdf_tx_engine.sv
module tdf_tx_engine
  import tdf_pkg::*;
#(
  parameter int RING_N = 4,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  localparam int IDX_W  = (RING_N > 1) ? $clog2(RING_N) : 1,
  localparam int DESC_W = STAT_W + LEN_W + ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [EVT_W-1:0]  evt_o,
  output logic              active_o,
  output logic              fdx_o,
  output logic              desc_rd_o,
  output logic              desc_wr_o,
  output logic [IDX_W-1:0]  desc_addr_o,
  input  logic [DESC_W-1:0] desc_rdata_i,
  output logic [STAT_W-1:0] desc_wdata_o,
  output logic              buf_rd_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [7:0]        buf_rdata_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_last_o,
  output logic              tx_crc_o
);
  logic gts, adv, wrap, clr_active, set_done, set_stop;

  tdf_regs i_regs (
    .clk_i, .rst_ni,
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .set_done_i  (set_done),
    .set_stop_i  (set_stop),
    .clr_active_i(clr_active),
    .gts_o       (gts),
    .fdx_o       (fdx_o),
    .active_o    (active_o),
    .evt_o       (evt_o)
  );

  tdf_ring_ptr #(.RING_N(RING_N)) i_ptr (
    .clk_i, .rst_ni,
    .adv_i (adv),
    .wrap_i(wrap),
    .idx_o (desc_addr_o)
  );

  tdf_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_seq (
    .clk_i, .rst_ni,
    .active_i    (active_o),
    .gts_i       (gts),
    .desc_rd_o, .desc_wr_o, .desc_rdata_i, .desc_wdata_o,
    .buf_rd_o, .buf_addr_o, .buf_rdata_i,
    .tx_valid_o, .tx_ready_i, .tx_data_o, .tx_last_o, .tx_crc_o,
    .adv_o       (adv),
    .wrap_o      (wrap),
    .clr_active_o(clr_active),
    .set_done_o  (set_done),
    .set_stop_o  (set_stop)
  );
endmodule

// File: rtl/tdf_tx_engine_chk.sv
module tdf_tx_engine_chk
  import tdf_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [7:0]        tx_data_o,
  input logic              desc_wr_o,
  input logic [STAT_W-1:0] desc_wdata_o,
  input logic [IDX_W-1:0]  desc_addr_o,
  input logic [EVT_W-1:0]  evt_o,
  input logic              active_o
);
  // R12
  stream_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  // R4
  done_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_wr_o |=> evt_o[EVT_DONE]);

  // R5
  wrap_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desc_wr_o && desc_wdata_o[WRAP_BIT] |=> desc_addr_o == '0);

  // R6
  send_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> active_o);

  // R9
  stop_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o[EVT_STOP]) |-> !tx_valid_o);
endmodule

bind tdf_tx_engine tdf_tx_engine_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_tdf_tx_engine.sv
module test_tdf_tx_engine;
  localparam logic [15:0] RDY = 16'h8000, WRP = 16'h2000, LST = 16'h0800,
                          TC = 16'h0400, SPARE = 16'h0011;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [1:0]  evt_o;
  logic        active_o, fdx_o, desc_rd_o, desc_wr_o, buf_rd_o;
  logic [1:0]  desc_addr_o;
  logic [63:0] desc_rdata_i = '0;
  logic [15:0] desc_wdata_o;
  logic [31:0] buf_addr_o;
  logic [7:0]  buf_rdata_i = '0;
  logic        tx_valid_o, tx_last_o, tx_crc_o;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;

  tdf_tx_engine i_tdf_tx_engine (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, fails = 0, frames = 0;
  logic [63:0] dmem [4];
  logic [7:0]  bmem [1024];
  logic [9:0]  expq [$];
  logic        hold_pend = 1'b0;
  logic [7:0]  hold_data = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model, serviced mid-cycle so requests are seen settled
  always @(negedge clk_i) begin
    if (desc_rd_o) desc_rdata_i = dmem[desc_addr_o];
    if (desc_wr_o) dmem[desc_addr_o][15:0] = desc_wdata_o;
    if (buf_rd_o)  buf_rdata_i = bmem[buf_addr_o[9:0]];
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (hold_pend) begin
        check(tx_valid_o && tx_data_o == hold_data, "R12", "held byte",
              {tx_valid_o, tx_data_o}, {1'b1, hold_data});
        hold_pend = 1'b0;
      end
      if (tx_valid_o && !tx_ready_i) begin
        hold_pend = 1'b1;
        hold_data = tx_data_o;
      end
      if (tx_valid_o && tx_ready_i) begin
        if (expq.size() == 0) check(1'b0, "R2", "unexpected byte", tx_data_o, 0);
        else begin
          logic [9:0] e;
          e = expq.pop_front();
          check(tx_data_o == e[7:0], "R2", "byte", tx_data_o, e[7:0]);
          check({tx_last_o, tx_crc_o} == e[9:8], "R3", "last/crc",
                {tx_last_o, tx_crc_o}, e[9:8]);
        end
        if (tx_last_o) frames++;
      end
    end
  end

  // sink backpressure pattern
  initial begin
    int n = 0;
    forever begin
      @(posedge clk_i); #1;
      n++;
      tx_ready_i = (n % 3) != 1;
    end
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk_i); #1;
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic set_desc(input int i, input logic [15:0] st, input int len, input int ptr);
    dmem[i] = {32'(ptr), 16'(len), st};
    if (st[15]) begin
      for (int k = 0; k < len; k++) begin
        logic lst;
        lst = st[11] && (k == len - 1);
        expq.push_back({lst, lst && st[10], bmem[ptr + k]});
      end
    end
  endtask

  task automatic wait_stop(input string req);
    int t = 0;
    while (active_o && t < 2000) begin @(posedge clk_i); #1; t++; end
    check(!active_o, req, "ring halted", active_o, 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  initial begin
    repeat (40000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int f0;
    for (int i = 0; i < 1024; i++) bmem[i] = 8'((i * 37) ^ (i >> 2));
    for (int i = 0; i < 4; i++) dmem[i] = '0;
    idle(3);
    #3 rst_ni = 1'b1;
    idle(1);
    // R1
    check(evt_o == 0 && !active_o && !fdx_o && !tx_valid_o && desc_addr_o == 0,
          "R1", "reset state", {evt_o, active_o, fdx_o, tx_valid_o, desc_addr_o}, 0);

    // R2 R3 R4 R6: one frame, next slot empty
    set_desc(0, RDY | LST | TC | SPARE, 5, 'h100);
    reg_write(1, 32'h0100_0000);
    wait_stop("R6");
    check(expq.size() == 0, "R2", "all bytes sent", expq.size(), 0);
    check(dmem[0][15:0] == (LST | TC | SPARE), "R4", "status write-back",
          dmem[0][15:0], LST | TC | SPARE);
    check(evt_o[1], "R4", "done event", evt_o, 2);
    check(dmem[1][15:0] == 0, "R6", "empty slot untouched", dmem[1][15:0], 0);
    check(desc_addr_o == 1, "R5", "slot advanced", desc_addr_o, 1);

    // R10 plain clear
    reg_write(2, 32'h2);
    check(evt_o == 0, "R10", "done cleared", evt_o, 0);

    // R8 chain, R13 zero length, R5 wrap at ring end
    set_desc(1, RDY, 3, 'h200);
    set_desc(2, RDY | LST, 2, 'h300);
    set_desc(3, RDY | LST | TC, 0, 'h380);
    reg_write(1, 32'h0100_0000);
    wait_stop("R8");
    check(expq.size() == 0, "R8", "chained bytes sent", expq.size(), 0);
    check(dmem[3][15:0] == (LST | TC), "R13", "zero length written back",
          dmem[3][15:0], LST | TC);
    check(desc_addr_o == 0, "R5", "wrap at ring end", desc_addr_o, 0);

    // R7 lone self-wrapping descriptor
    f0 = frames;
    set_desc(0, RDY | LST | WRP, 4, 'h40);
    reg_write(1, 32'h0100_0000);
    wait_stop("R7");
    idle(20);
    check(frames - f0 == 1, "R7", "frames sent", frames - f0, 1);
    check(expq.size() == 0, "R7", "bytes sent", expq.size(), 0);

    // R9 graceful stop mid-frame
    reg_write(2, 32'h3);
    set_desc(0, RDY, 4, 'h10);
    set_desc(1, RDY | LST | TC, 4, 'h20);
    dmem[2] = {32'h30, 16'd2, RDY | LST | WRP};
    reg_write(1, 32'h0100_0000);
    begin
      int t = 0;
      while (expq.size() > 7 && t < 500) begin idle(1); t++; end
    end
    reg_write(0, 32'h1);
    begin
      int t = 0;
      while (!evt_o[0] && t < 1000) begin idle(1); t++; end
    end
    check(evt_o[0], "R9", "stop event", evt_o, 1);
    check(expq.size() == 0, "R9", "frame finished", expq.size(), 0);
    idle(40);
    check(dmem[2][15] && active_o, "R9", "held while stopped",
          {dmem[2][15], active_o}, 2'b11);
    set_desc(2, RDY | LST | WRP, 2, 'h30);
    reg_write(0, 32'h0);
    wait_stop("R9");
    check(expq.size() == 0 && !dmem[2][15], "R9", "resumed",
          {expq.size(), dmem[2][15]}, 0);
    check(desc_addr_o == 0, "R5", "wrap flag", desc_addr_o, 0);

    // R10 event set and clear in the same cycle
    reg_write(2, 32'h1);
    check(evt_o == 2'b10, "R10", "stop cleared, done kept", evt_o, 2);
    set_desc(0, RDY | LST, 2, 'h50);
    reg_write(1, 32'h0100_0000);
    begin
      int t = 0;
      @(negedge clk_i);
      while (!desc_wr_o && t < 500) begin @(negedge clk_i); t++; end
      reg_wr_i = 1'b1; reg_addr_i = 2'd2; reg_wdata_i = 32'h2;
      @(posedge clk_i); #1;
      reg_wr_i = 1'b0;
    end
    check(evt_o[1], "R10", "set wins over clear", evt_o, 2);
    wait_stop("R10");
    reg_write(2, 32'h2);
    check(evt_o == 0, "R10", "later clear", evt_o, 0);

    // R11
    reg_write(0, 32'h4);
    check(fdx_o, "R11", "full duplex set", fdx_o, 1);
    reg_write(0, 32'h0);
    check(!fdx_o, "R11", "full duplex clear", fdx_o, 0);

    idle(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule